// File: doc/BRIEF.md
# Interrupt Control Bus-Cycle Sequencer

This block issues the special read cycles that a processor core places on its external bus when it takes a non-maskable interrupt or a maskable interrupt, and when it returns from a vectored service routine. The core hands it one request of a given kind. The sequencer then runs one or two single-byte read cycles. Each cycle presents a target address, a 4-bit status code, a high-byte-lane enable, a read strobe and a read direction. The sequencer waits for the bus to signal ready, takes the byte from the correct half of the 16-bit data bus, and reports the result with a one-cycle done pulse.

A vectored acknowledge first reads the master interrupt controller. If the returned byte has bit 7 clear, that byte is the vector. If bit 7 is set, the byte is a negative cascade index. Its low four bits select an entry in a 16-entry table of 24-bit cascade addresses. A second read with its own status code then goes to that address and fetches the real vector. A vectored return follows the same pattern with the two return status codes. For a return, the byte from the first cycle is the value that gets reported.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A requester facing a low `req_ready` must hold `req_valid` and `req_kind` steady until the request is taken. The result outputs give no back-pressure: `done` is a single-cycle pulse, and `done_vec`/`done_casc` keep their value until the next sequence ends.

Top module: `irq_bus_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `bus_rd`, `bus_dir_rd` and `done` are 0.
- R2: Every cycle the block runs is a read. `bus_dir_rd` is 1 whenever `bus_rd` is 1, and the status code always has the form 01xx.
- R3: With `req_kind`=0 (non-maskable), one cycle runs at address FFFF00h with status 0100. `done_vec` is then 0 whatever byte was returned.
- R4: With `req_kind`=1 (non-vectored), one cycle runs at FFFE00h with status 0100. The returned byte is ignored and `done_vec` is 0.
- R5: With `req_kind`=2 (vectored acknowledge), the first cycle is at FFFE00h with status 0100. If the byte has bit 7 clear, the sequence ends there, `done_vec` equals that byte and `done_casc` is 0.
- R6: With `req_kind`=2, if the first byte has bit 7 set, a second cycle runs with status 0101 at the table entry selected by byte bits [3:0]. `done_vec` is the second byte and `done_casc` is 1.
- R7: With `req_kind`=3 (vectored return), the first cycle is at FFFE00h with status 0110. If that byte has bit 7 set, a second cycle runs at the selected table entry with status 0111. In both cases `done_vec` is the first byte, and `done_casc` shows whether the second cycle ran.
- R8: For an odd address (bit 0 set), `bus_hbe_n` is 0 and the byte comes from `bus_data[15:8]`. For an even address, `bus_hbe_n` is 1 and the byte comes from `bus_data[7:0]`.
- R9: A cycle holds `bus_rd`, `bus_addr` and `bus_status` steady until it sees `bus_rdy` high on a clock edge.
- R10: `done` goes high for exactly one cycle, on the edge after the `bus_rdy` that ends the last cycle. On that same cycle `bus_rd` is already 0 and `req_ready` is 1.
- R11: `req_ready` is 0 while a sequence runs. A request held during that time is taken only after `done`, and it then runs normally.
- R12: When `tbl_we` is high on a clock edge, entry `tbl_idx` of the cascade table is set to `tbl_addr`. Later cascaded cycles use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 non-maskable, 1 non-vectored, 2 vectored acknowledge, 3 vectored return |
| tbl_we | input | 1 | Cascade table write enable |
| tbl_idx | input | 4 | Cascade table entry to write |
| tbl_addr | input | 24 | Cascade address to store |
| bus_addr | output | 24 | Cycle address |
| bus_status | output | 4 | Cycle status code |
| bus_hbe_n | output | 1 | High byte lane enable, active low |
| bus_rd | output | 1 | Read strobe, high for the whole cycle |
| bus_dir_rd | output | 1 | Data direction, 1 = read |
| bus_rdy | input | 1 | Bus ready, ends the current cycle |
| bus_data | input | 16 | Read data |
| done | output | 1 | Sequence finished, one-cycle pulse |
| done_vec | output | 8 | Reported vector or index |
| done_casc | output | 1 | A second cascaded cycle ran |

## Verification
The bench runs every first-cycle byte value, 0 to 255, through both the vectored acknowledge and the return. This catches a design that tests the wrong bit for a cascade, that masks the table index wrongly, or that reports the second byte for a return. The table holds both odd and even addresses, so a design that reverses the lane choice or the `bus_hbe_n` polarity reads the decoy byte placed on the other half of the bus. The bench also varies the number of wait cycles and offers a request while a sequence is running. A design that drops the address during a wait, or that takes a request while busy, shows a wrong address or a missing cycle. The non-maskable and non-vectored runs use nonzero data, so a design that does not ignore that byte reports a wrong `done_vec`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    RQ_NMI  = 2'd0,
    RQ_NVI  = 2'd1,
    RQ_VACK = 2'd2,
    RQ_VRET = 2'd3
  } rq_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FIRST,
    SQ_SECOND
  } sq_state_e;

  localparam logic [3:0] ST_ACK_MASTER = 4'b0100;
  localparam logic [3:0] ST_ACK_CASC   = 4'b0101;
  localparam logic [3:0] ST_RET_MASTER = 4'b0110;
  localparam logic [3:0] ST_RET_CASC   = 4'b0111;

endpackage

// File: rtl/irq_casc_table.sv
module irq_casc_table #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 24,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);

  logic [ADDR_W-1:0] entry_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
    end else if (wr_en) begin
      entry_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_idx];

endmodule

// File: rtl/irq_lane_pick.sv
module irq_lane_pick #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] data,
  input  logic [SEL_W-1:0]  lane_sel,
  output logic [7:0]        lane_byte,
  output logic              hi_lane_n
);

  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = data[g*8 +: 8];
  end

  assign lane_byte = lanes[lane_sel];
  assign hi_lane_n = (lane_sel == '0);

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 4,
  parameter logic [ADDR_W-1:0] MASTER_ADDR = 24'hFFFE00,
  parameter logic [ADDR_W-1:0] NMI_ADDR    = 24'hFFFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  output logic              req_ready,
  input  logic              bus_rdy,
  input  logic [7:0]        rsp_byte,
  output logic [IDX_W-1:0]  tbl_rd_idx,
  input  logic [ADDR_W-1:0] tbl_rd_data,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [3:0]        cyc_status,
  output logic              cyc_active,
  output logic              done,
  output logic [7:0]        done_vec,
  output logic              done_casc
);

  sq_state_e         state_q;
  rq_kind_e          kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        status_q;
  logic [7:0]        first_q;
  logic              done_q;
  logic [7:0]        vec_q;
  logic              casc_q;

  logic is_vectored;
  logic casc_hit;
  logic vec_drop;

  always_comb begin
    is_vectored = (kind_q == RQ_VACK) || (kind_q == RQ_VRET);
    casc_hit    = is_vectored && rsp_byte[7];
    vec_drop    = !is_vectored;
    tbl_rd_idx  = rsp_byte[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      kind_q   <= RQ_NMI;
      addr_q   <= '0;
      status_q <= '0;
      first_q  <= '0;
      done_q   <= 1'b0;
      vec_q    <= '0;
      casc_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (req_valid) begin
            kind_q   <= rq_kind_e'(req_kind);
            addr_q   <= (rq_kind_e'(req_kind) == RQ_NMI) ? NMI_ADDR : MASTER_ADDR;
            status_q <= (rq_kind_e'(req_kind) == RQ_VRET) ? ST_RET_MASTER : ST_ACK_MASTER;
            state_q  <= SQ_FIRST;
          end
        end
        SQ_FIRST: begin
          if (bus_rdy) begin
            first_q <= rsp_byte;
            if (casc_hit) begin
              addr_q   <= tbl_rd_data;
              status_q <= (kind_q == RQ_VRET) ? ST_RET_CASC : ST_ACK_CASC;
              state_q  <= SQ_SECOND;
            end else begin
              state_q <= SQ_IDLE;
              done_q  <= 1'b1;
              casc_q  <= 1'b0;
              vec_q   <= vec_drop ? 8'h00 : rsp_byte;
            end
          end
        end
        SQ_SECOND: begin
          if (bus_rdy) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
            casc_q  <= 1'b1;
            vec_q   <= (kind_q == RQ_VRET) ? first_q : rsp_byte;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == SQ_IDLE);
  assign cyc_active = (state_q != SQ_IDLE);
  assign cyc_addr   = addr_q;
  assign cyc_status = status_q;
  assign done       = done_q;
  assign done_vec   = vec_q;
  assign done_casc  = casc_q;

endmodule

// File: rtl/irq_bus_seq.sv
module irq_bus_seq #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int TBL_DEPTH = 16,
  parameter logic [ADDR_W-1:0] MASTER_ADDR = 24'hFFFE00,
  parameter logic [ADDR_W-1:0] NMI_ADDR    = 24'hFFFF00,
  localparam int IDX_W = $clog2(TBL_DEPTH),
  localparam int LANES = DATA_W / 8,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_addr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_status,
  output logic              bus_hbe_n,
  output logic              bus_rd,
  output logic              bus_dir_rd,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_data,
  output logic              done,
  output logic [7:0]        done_vec,
  output logic              done_casc
);

  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] rd_entry;
  logic [7:0]        picked;
  logic              active;

  irq_casc_table #(.DEPTH(TBL_DEPTH), .ADDR_W(ADDR_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_data (tbl_addr),
    .rd_idx  (rd_idx),
    .rd_data (rd_entry)
  );

  irq_lane_pick #(.DATA_W(DATA_W)) u_lane (
    .data      (bus_data),
    .lane_sel  (bus_addr[SEL_W-1:0]),
    .lane_byte (picked),
    .hi_lane_n (bus_hbe_n)
  );

  irq_seq_ctrl #(
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .MASTER_ADDR (MASTER_ADDR),
    .NMI_ADDR    (NMI_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_ready   (req_ready),
    .bus_rdy     (bus_rdy),
    .rsp_byte    (picked),
    .tbl_rd_idx  (rd_idx),
    .tbl_rd_data (rd_entry),
    .cyc_addr    (bus_addr),
    .cyc_status  (bus_status),
    .cyc_active  (active),
    .done        (done),
    .done_vec    (done_vec),
    .done_casc   (done_casc)
  );

  assign bus_rd     = active;
  assign bus_dir_rd = active;

endmodule

// File: rtl/irq_bus_seq_chk.sv
module irq_bus_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_rd,
  input logic              bus_dir_rd,
  input logic              bus_rdy,
  input logic              bus_hbe_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_status,
  input logic              done
);

  // R2
  read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_dir_rd);

  // R2
  status_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_status[3:2] == 2'b01));

  // R8
  lane_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_hbe_n == !bus_addr[0]));

  // R9
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_rdy) |=> (bus_rd && $stable(bus_addr) && $stable(bus_status)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !bus_rd));

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !req_ready);

endmodule

bind irq_bus_seq irq_bus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .bus_rd     (bus_rd),
  .bus_dir_rd (bus_dir_rd),
  .bus_rdy    (bus_rdy),
  .bus_hbe_n  (bus_hbe_n),
  .bus_addr   (bus_addr),
  .bus_status (bus_status),
  .done       (done)
);

// File: tb/irq_bus_seq_test.sv
`timescale 1ns/1ps
module irq_bus_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [23:0] tbl_addr = '0;
  logic [23:0] bus_addr;
  logic [3:0]  bus_status;
  logic        bus_hbe_n;
  logic        bus_rd;
  logic        bus_dir_rd;
  logic        bus_rdy = 1'b0;
  logic [15:0] bus_data = '0;
  logic        done;
  logic [7:0]  done_vec;
  logic        done_casc;

  int n_checks = 0;
  int n_fail = 0;
  logic [23:0] model [16];

  always #4 clk = ~clk;

  irq_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr),
    .bus_addr(bus_addr), .bus_status(bus_status), .bus_hbe_n(bus_hbe_n),
    .bus_rd(bus_rd), .bus_dir_rd(bus_dir_rd), .bus_rdy(bus_rdy), .bus_data(bus_data),
    .done(done), .done_vec(done_vec), .done_casc(done_casc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wr_tbl(input logic [3:0] idx, input logic [23:0] val);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_addr = val;
    @(negedge clk);
    tbl_we = 1'b0;
    model[idx] = val;
  endtask

  // Entered at a negedge inside the cycle; leaves at the negedge after bus_rdy.
  task automatic serve(input logic [23:0] ea, input logic [3:0] est,
                       input logic [7:0] b, input int waits, input string tag);
    logic exp_hbe;
    exp_hbe = ea[0] ? 1'b0 : 1'b1;
    chk(bus_rd === 1'b1, tag, "R2 bus_rd", {31'd0, bus_rd}, 32'd1);
    chk(bus_dir_rd === 1'b1, tag, "R2 bus_dir_rd", {31'd0, bus_dir_rd}, 32'd1);
    chk(bus_addr === ea, tag, "bus_addr", {8'd0, bus_addr}, {8'd0, ea});
    chk(bus_status === est, tag, "bus_status", {28'd0, bus_status}, {28'd0, est});
    chk(bus_hbe_n === exp_hbe, "R8", "bus_hbe_n", {31'd0, bus_hbe_n}, {31'd0, exp_hbe});
    chk(req_ready === 1'b0, "R11", "req_ready busy", {31'd0, req_ready}, 32'd0);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk(bus_rd === 1'b1 && bus_addr === ea && bus_status === est, "R9",
          "held cycle addr", {8'd0, bus_addr}, {8'd0, ea});
      chk(done === 1'b0, "R10", "done early", {31'd0, done}, 32'd0);
    end
    bus_rdy = 1'b1;
    bus_data = ea[0] ? {b, 8'h5A} : {8'hA5, b};
    @(negedge clk);
    bus_rdy = 1'b0;
    bus_data = 16'hDEAD;
  endtask

  // Assumes the request was accepted and the sequencer is in its first cycle.
  task automatic run_body(input logic [1:0] k, input logic [7:0] b1,
                          input logic [7:0] b2, input int waits, input string tag);
    logic [23:0] a1;
    logic [3:0]  s1;
    logic        casc;
    logic [7:0]  ev;
    a1 = (k == 2'd0) ? 24'hFFFF00 : 24'hFFFE00;
    s1 = (k == 2'd3) ? 4'b0110 : 4'b0100;
    serve(a1, s1, b1, waits, tag);
    casc = (k >= 2'd2) && b1[7];
    if (casc) begin
      serve(model[b1[3:0]], (k == 2'd3) ? 4'b0111 : 4'b0101, b2, waits, tag);
    end
    if (k < 2'd2) ev = 8'h00;
    else if (casc && k == 2'd2) ev = b2;
    else ev = b1;
    chk(done === 1'b1, "R10", "done pulse", {31'd0, done}, 32'd1);
    chk(done_vec === ev, tag, "done_vec", {24'd0, done_vec}, {24'd0, ev});
    chk(done_casc === casc, tag, "done_casc", {31'd0, done_casc}, {31'd0, casc});
    chk(req_ready === 1'b1 && bus_rd === 1'b0, "R10", "idle at done",
        {30'd0, req_ready, bus_rd}, 32'd2);
  endtask

  task automatic run_req(input logic [1:0] k, input logic [7:0] b1,
                         input logic [7:0] b2, input int waits, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    run_body(k, b1, b2, waits, tag);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready === 1'b1, "R1", "reset req_ready", {31'd0, req_ready}, 32'd1);
    chk(bus_rd === 1'b0 && bus_dir_rd === 1'b0, "R1", "reset bus idle",
        {30'd0, bus_rd, bus_dir_rd}, 32'd0);
    chk(done === 1'b0, "R1", "reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;

    // R12: odd and even cascade addresses
    for (int i = 0; i < 16; i++) wr_tbl(4'(i), 24'hC00000 | 24'(i << 8) | 24'(i));

    // R3 and R4: the returned data must not leak into done_vec
    for (int d = 1; d < 256; d += 37) begin
      run_req(2'd0, 8'(d), 8'h00, d % 3, "R3");
      run_req(2'd1, 8'(d), 8'h00, d % 2, "R4");
    end

    // R5, R6, R7: every first-cycle byte
    for (int b = 0; b < 256; b++) begin
      run_req(2'd2, 8'(b), 8'(255 - b), b % 3, b[7] ? "R6" : "R5");
      run_req(2'd3, 8'(b), 8'(b ^ 8'h3C), (b + 1) % 2, "R7");
    end

    // R12: rewriting an entry redirects the next cascaded cycle
    wr_tbl(4'd5, 24'h123457);
    run_req(2'd2, 8'hF5, 8'h42, 1, "R12");
    wr_tbl(4'd5, 24'h00ABC0);
    run_req(2'd3, 8'hF5, 8'h00, 0, "R12");

    // R11: request offered while busy is held and taken after done
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd2;
    @(negedge clk);
    req_kind = 2'd0;
    chk(req_ready === 1'b0, "R11", "ready low after accept", {31'd0, req_ready}, 32'd0);
    run_body(2'd2, 8'hFA, 8'h66, 2, "R11");
    @(negedge clk);
    req_valid = 1'b0;
    run_body(2'd0, 8'h77, 8'h00, 1, "R11");
    @(negedge clk);
    chk(bus_rd === 1'b0 && req_ready === 1'b1, "R11", "single run of held request",
        {30'd0, bus_rd, req_ready}, 32'd1);

    report();
  end

endmodule